// File: doc/BRIEF.md
# Memory-Mapped UART Register Slave

This block lets a processor drive a byte-oriented serial port through three word-aligned registers on a valid/ready memory bus. A store to the transmit register passes the low byte of the write data to a byte-wide transmitter over a valid/ready byte handshake. If the transmitter cannot take the byte yet, the bus request is stalled. Bytes from the receiver are placed in an internal receive FIFO. A load of the receive register returns the oldest byte and removes it from the FIFO as a side effect. A status register reports whether the transmitter is busy and whether received data is waiting.

The slave serves one access at a time. Each accepted request produces one registered response in the next cycle. The response is held until the master takes it, and the next request is not accepted before then. Accesses the slave cannot serve complete with the error flag set and have no side effect.

The address port carries only the offset inside the block. Decoding of the wider system address happens elsewhere.

Top module: `mmio_uart_regs`

## Requirements
- R1: After reset no response is pending, `tx_valid` is low and the receive FIFO is empty. A status read with `tx_ready` high then returns 0.
- R2: A write (`req_we`=1) to offset 0x0 while `tx_ready` is high raises `tx_valid` in the acceptance cycle, with `tx_byte` equal to `req_wdata[7:0]`. Exactly one byte is handed over, and the response has `rsp_err`=0.
- R3: A write to offset 0x0 while `tx_ready` is low keeps `req_ready` low and `tx_valid` high, and hands over no byte. When `tx_ready` rises, the write is accepted and completes.
- R4: A read of offset 0x4 with data in the FIFO returns the oldest byte in `rsp_rdata[7:0]` with bits 31:8 zero and `rsp_err`=0, and removes that byte. Bytes come out in arrival order.
- R5: A read of offset 0x4 while the FIFO is empty returns 0 with `rsp_err`=0, and leaves the FIFO unchanged.
- R6: A read of offset 0x8 returns bit 0 = NOT `tx_ready` and bit 1 = FIFO non-empty, both taken at acceptance, with all other bits zero and `rsp_err`=0.
- R7: The following accesses respond with `rsp_err`=1 and `rsp_rdata`=0, hand no byte to the transmitter and pop nothing:
  - writes to 0x4 or 0x8;
  - reads of 0x0;
  - any access to any other offset.
- R8: The FIFO holds DEPTH bytes. A byte arriving on `rx_valid` while the FIFO is full is dropped.
- R9: The response appears in the cycle after acceptance. It stays valid with stable data and error until `rsp_ready` is high. `req_ready` is low while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W | Byte offset inside the block |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data; bits 7:0 used |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Master takes the response |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access could not be served |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_byte | output | 8 | Byte to transmit |
| rx_valid | input | 1 | One received byte this cycle |
| rx_byte | input | 8 | Received byte |

## Verification
The assertions assume that the master keeps its request fields steady while `req_valid` is high and not yet accepted. They also assume that `rx_valid` is a single-cycle strobe per byte. The bench drives every request at the falling edge and holds it unchanged until acceptance. It pulses `rx_valid` for one cycle per byte.

The assertions assume that `tx_ready` is driven only by the transmitter stub. The bench changes `tx_ready` only at falling edges, so a stalled write sees one steady level for each rising edge.

// File: rtl/mmio_uart_regs.sv
module mmio_uart_regs #(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_byte,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    fifo [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fill;
  logic sel_tx, sel_rx, sel_st, legal, accept, empty, full, push, pop;
  logic unused_wdata;

  assign sel_tx = req_addr == ADDR_W'(0);
  assign sel_rx = req_addr == ADDR_W'(4);
  assign sel_st = req_addr == ADDR_W'(8);
  assign legal  = (sel_tx && req_we) || ((sel_rx || sel_st) && !req_we);

  assign tx_valid  = req_valid && !rsp_valid && sel_tx && req_we;
  assign tx_byte   = req_wdata[7:0];
  assign req_ready = !rsp_valid && (!(sel_tx && req_we) || tx_ready);
  assign accept    = req_valid && req_ready;

  assign empty = fill == '0;
  assign full  = fill == CW'(DEPTH);
  assign push  = rx_valid && !full;
  assign pop   = accept && sel_rx && !req_we && !empty;
  assign unused_wdata = ^req_wdata[31:8];

  always_ff @(posedge clk)
    if (push) fifo[wp] <= rx_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= !legal;
      if (!legal)      rsp_rdata <= '0;
      else if (sel_rx) rsp_rdata <= {24'd0, empty ? 8'd0 : fifo[rp]};
      else if (sel_st) rsp_rdata <= {30'd0, !empty, !tx_ready};
      else             rsp_rdata <= '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mmio_uart_regs_chk.sv
module mmio_uart_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_we,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        rsp_err,
  input logic        tx_valid,
  input logic        tx_ready
);
  assert_rsp_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  assert_no_accept_pending_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  assert_tx_stall_R3: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |-> !req_ready);

  assert_tx_from_write_R2: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> req_valid && req_we && !rsp_valid);

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_rdata[31:8] == 24'd0);

  assert_err_data_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> rsp_rdata == 32'd0);
endmodule

bind mmio_uart_regs mmio_uart_regs_chk chk (.*);

// File: tb/mmio_uart_regs_test.sv
module mmio_uart_regs_test;
  localparam int PERIOD = 10;
  localparam int D = 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_we = 0, rsp_ready = 1, tx_ready = 1, rx_valid = 0;
  logic [3:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [7:0] rx_byte = 0;
  logic req_ready, rsp_valid, rsp_err, tx_valid;
  logic [31:0] rsp_rdata;
  logic [7:0] tx_byte;
  logic [31:0] rd;
  logic e;
  int checks = 0, errors = 0, tx_cnt = 0;
  logic [7:0] tx_log = 0;

  mmio_uart_regs #(.ADDR_W(4), .DEPTH(D)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk)
    if (!rst && tx_valid && tx_ready) begin
      tx_log <= tx_byte;
      tx_cnt <= tx_cnt + 1;
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [3:0] a, input logic [31:0] d,
                        output logic [31:0] r, output logic er);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    #1;
    chk("R9 response next cycle", {31'd0, rsp_valid}, 1);
    r = rsp_rdata; er = rsp_err;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 0);
    chk("R1 tx_valid after reset", {31'd0, tx_valid}, 0);
    access(0, 4'h8, 0, rd, e);
    chk("R1 status after reset", rd, 0);

    for (int i = 0; i < 256; i++) begin
      base = tx_cnt;
      access(1, 4'h0, {8'(i * 3), 8'(255 - i), 8'(i + 7), 8'(i)}, rd, e);
      chk("R2 tx byte", {24'd0, tx_log}, i);
      chk("R2 one transfer", tx_cnt - base, 1);
      chk("R2 no error", {31'd0, e}, 0);
    end

    tx_ready = 0;
    access(0, 4'h8, 0, rd, e);
    chk("R6 status busy", rd, 1);
    base = tx_cnt;
    fork
      access(1, 4'h0, 32'hFFFF_FF5C, rd, e);
      begin
        repeat (4) @(negedge clk);
        #2;
        chk("R3 stalled req_ready", {31'd0, req_ready}, 0);
        chk("R3 tx_valid offered", {31'd0, tx_valid}, 1);
        chk("R3 no transfer while busy", tx_cnt - base, 0);
        @(negedge clk);
        tx_ready = 1;
      end
    join
    chk("R3 byte after release", {24'd0, tx_log}, 32'h5C);
    chk("R3 one transfer", tx_cnt - base, 1);
    chk("R3 no error", {31'd0, e}, 0);

    for (int n = 0; n <= D + 2; n++) begin
      for (int k = 0; k < n; k++) push(8'(n * 16 + k + 1));
      access(0, 4'h8, 0, rd, e);
      chk("R6 status rx available", rd, (n > 0) ? 2 : 0);
      for (int k = 0; k < ((n < D) ? n : D); k++) begin
        access(0, 4'h4, 0, rd, e);
        chk("R4 fifo order", rd, 8'(n * 16 + k + 1));
        chk("R4 no error", {31'd0, e}, 0);
      end
      access(0, 4'h4, 0, rd, e);
      chk("R8 overflow dropped / R5 empty read", rd, 0);
      chk("R5 no error", {31'd0, e}, 0);
    end

    access(0, 4'h4, 0, rd, e);
    chk("R5 empty read zero", rd, 0);
    push(8'h3D);
    access(0, 4'h4, 0, rd, e);
    chk("R5 fifo unchanged by empty read", rd, 32'h3D);

    push(8'hA5);
    base = tx_cnt;
    for (int a = 0; a < 16; a++)
      for (int w = 0; w < 2; w++)
        if (!((a == 0 && w == 1) || ((a == 4 || a == 8) && w == 0))) begin
          access(w[0], 4'(a), 32'hDEAD_BE00 | 32'(a), rd, e);
          chk("R7 error flag", {31'd0, e}, 1);
          chk("R7 error data zero", rd, 0);
        end
    chk("R7 no tx on error", tx_cnt - base, 0);
    access(0, 4'h4, 0, rd, e);
    chk("R7 no pop on error", rd, 32'hA5);

    push(8'h77);
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_we = 0; req_addr = 4'h8;
    @(posedge clk);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk("R9 response held", {31'd0, rsp_valid}, 1);
      chk("R9 no accept while pending", {31'd0, req_ready}, 0);
      chk("R9 held data", rsp_rdata, 2);
    end
    req_valid = 0;
    rsp_ready = 1;
    @(negedge clk); #1;
    chk("R9 response taken", {31'd0, rsp_valid}, 0);
    access(0, 4'h4, 0, rd, e);
    chk("R9 single pop", rd, 32'h77);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule